// File: doc/BRIEF.md
# Hardware Semaphore Allocation Pool

The block keeps a small pool of binary semaphores, each either free or busy, and services allocate, release and status operations. Every operation completes as one indivisible step, so no two requesters can come away owning the same entry. A requester can ask for one particular entry by number, or for "any" entry, in which case the lowest-numbered free entry is taken.

Several requesters share the pool through separate request ports. When more than one port presents a request in the same cycle, the lowest-numbered port wins. Exactly one request is served per cycle. A port whose request is not accepted keeps it asserted until its `reqReady` bit rises.

Each served request gets one registered response: a success bit and an index. The index is either the entry acted on, or the failure code with all bits set. The busy state of every entry is visible at all times on a flat vector.

Top module: `sem_pool`

## Requirements
- R1: After reset every entry is free (`busyVec` all zero), `rspValid` is zero and `reqReady` is zero while no request is valid.
- R2: An acquire (op 2'b01, `reqAny`=0) of an in-range free entry makes it busy and responds with success and that index. The response, with `rspValid` bit p set for serving port p, appears on the clock edge that accepts the request.
- R3: An acquire of a specific entry that is already busy responds with failure and index all ones (15 for the default), and changes no entry.
- R4: An acquire with `reqAny`=1 ignores `reqIdx`, takes the lowest-numbered free entry, marks it busy and returns its index with success.
- R5: An acquire with `reqAny`=1 while every entry is busy responds with failure and index all ones.
- R6: A specific acquire, release or status whose index is not below the pool size (10 by default) responds with failure and index all ones and changes no entry.
- R7: A release (op 2'b10) of an in-range entry leaves it free and responds with success and that index; releasing a free entry changes nothing else.
- R8: A status query (op 2'b00) of an in-range entry responds with the success bit equal to that entry's busy bit and the index echoed, and changes no entry.
- R9: At most one `reqReady` bit is high, only for a valid port, and it goes to the lowest-numbered valid port. Exactly one request is served per cycle.
- R10: Two same-cycle acquires of one free entry grant it only to the higher-priority port; the other port, served next cycle, fails.
- R11: The reserved op code 2'b11 responds with failure and index all ones and changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | NUM_REQ | Request present, one bit per port |
| reqOp | input | 2*NUM_REQ | Operation per port: 00 status, 01 acquire, 10 release, 11 reserved |
| reqIdx | input | IDX_W*NUM_REQ | Entry index per port |
| reqAny | input | NUM_REQ | Acquire the lowest free entry instead of `reqIdx` |
| reqReady | output | NUM_REQ | One-hot: the port whose request is taken this cycle |
| rspValid | output | NUM_REQ | One-hot: the port answered this cycle |
| rspOk | output | 1 | Success, or busy bit for a status query |
| rspIdx | output | IDX_W | Entry index, or all ones on failure |
| busyVec | output | NUM_SEMS | Busy bit of every entry |

## Verification
Single-port sweeps run every index value, including all out-of-range ones, through status, specific acquire, release and the reserved code. They are run on an empty pool, a half-filled pool and a full pool, which separates range rejection from busy rejection. Repeated "any" acquires on a pool with scattered holes tell the lowest-free search apart from any fixed or round-robin pick, and a full pool exercises the failure code. Same-cycle contention on both ports shows priority order, one-per-cycle service and that a contested entry is granted once. A pseudo-random mixed stream on both ports is compared against an arithmetic model of the pool.

// File: rtl/sem_pool_pkg.sv
package sem_pool_pkg;

  typedef enum logic [1:0] {
    OP_STATUS  = 2'b00,
    OP_ACQUIRE = 2'b01,
    OP_RELEASE = 2'b10,
    OP_RSVD    = 2'b11
  } semOp_e;

  // Strobes from control to datapath for the request served this cycle
  typedef struct packed {
    logic fire;     // some request is served
    logic doAcq;    // acquire, not rejected
    logic doRel;    // release, not rejected
    logic doStat;   // status, not rejected
    logic useAny;   // acquire targets the lowest free entry
    logic reject;   // fails without looking at pool state
  } semStrb_t;

endpackage

// File: rtl/sem_pool_arb.sv
module sem_pool_arb #(
  parameter int NUM_REQ = 2,
  parameter int IDX_W   = 4
) (
  input  logic [NUM_REQ-1:0]       reqValid,
  input  logic [2*NUM_REQ-1:0]     reqOp,
  input  logic [IDX_W*NUM_REQ-1:0] reqIdx,
  input  logic [NUM_REQ-1:0]       reqAny,
  output logic [NUM_REQ-1:0]       selPort,
  output logic                     selValid,
  output logic [1:0]               selOp,
  output logic [IDX_W-1:0]         selIdx,
  output logic                     selAny
);

  // Fixed priority: scan from the top so the lowest valid port is left last
  always_comb begin
    selPort  = '0;
    selValid = 1'b0;
    selOp    = 2'b00;
    selIdx   = '0;
    selAny   = 1'b0;
    for (int p = NUM_REQ - 1; p >= 0; p--) begin
      if (reqValid[p]) begin
        selPort    = '0;
        selPort[p] = 1'b1;
        selValid   = 1'b1;
        selOp      = reqOp[2*p +: 2];
        selIdx     = reqIdx[IDX_W*p +: IDX_W];
        selAny     = reqAny[p];
      end
    end
  end

endmodule

// File: rtl/sem_pool_ctrl.sv
module sem_pool_ctrl
  import sem_pool_pkg::*;
#(
  parameter int NUM_SEMS = 10,
  parameter int IDX_W    = 4
) (
  input  logic             selValid,
  input  logic [1:0]       selOp,
  input  logic [IDX_W-1:0] selIdx,
  input  logic             selAny,
  output semStrb_t         strb
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SEMS - 1);

  logic inRange;
  logic isAcq, isRel, isStat, isRsvd, anyAcq;

  always_comb begin
    inRange = (selIdx <= LAST_IDX);
    isAcq   = selValid && (selOp == OP_ACQUIRE);
    isRel   = selValid && (selOp == OP_RELEASE);
    isStat  = selValid && (selOp == OP_STATUS);
    isRsvd  = selValid && (selOp == OP_RSVD);
    anyAcq  = isAcq && selAny;

    strb.fire   = selValid;
    strb.reject = isRsvd || (selValid && !isRsvd && !anyAcq && !inRange);
    strb.doAcq  = isAcq  && !strb.reject;
    strb.doRel  = isRel  && !strb.reject;
    strb.doStat = isStat && !strb.reject;
    strb.useAny = anyAcq;
  end

endmodule

// File: rtl/sem_pool_dp.sv
module sem_pool_dp
  import sem_pool_pkg::*;
#(
  parameter int NUM_SEMS = 10,
  parameter int NUM_REQ  = 2,
  parameter int IDX_W    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  semStrb_t            strb,
  input  logic [IDX_W-1:0]    selIdx,
  input  logic [NUM_REQ-1:0]  selPort,
  output logic [NUM_SEMS-1:0] busyVec,
  output logic [NUM_REQ-1:0]  rspValid,
  output logic                rspOk,
  output logic [IDX_W-1:0]    rspIdx
);

  localparam logic [IDX_W-1:0] FAIL_CODE = '1;

  logic [NUM_SEMS-1:0] busyQ, busyD;
  logic [NUM_REQ-1:0]  rspValidQ;
  logic                rspOkQ;
  logic [IDX_W-1:0]    rspIdxQ;

  logic             freeHit;
  logic [IDX_W-1:0] freeIdx;
  logic [IDX_W-1:0] tgtIdx;
  logic             tgtBusy;
  logic             grantOk;
  logic             okD;
  logic [IDX_W-1:0] idxD;

  // Lowest free entry: scan downward so the smallest index is kept
  always_comb begin
    freeHit = 1'b0;
    freeIdx = '0;
    for (int i = NUM_SEMS - 1; i >= 0; i--) begin
      if (!busyQ[i]) begin
        freeHit = 1'b1;
        freeIdx = IDX_W'(i);
      end
    end
  end

  // Test and set in one step
  always_comb begin
    tgtIdx  = strb.useAny ? freeIdx : selIdx;
    tgtBusy = 1'b0;
    for (int i = 0; i < NUM_SEMS; i++) begin
      if (tgtIdx == IDX_W'(i)) tgtBusy = busyQ[i];
    end
    grantOk = strb.doAcq && (strb.useAny ? freeHit : !tgtBusy);

    busyD = busyQ;
    for (int i = 0; i < NUM_SEMS; i++) begin
      if (grantOk && (tgtIdx == IDX_W'(i)))      busyD[i] = 1'b1;
      if (strb.doRel && (selIdx == IDX_W'(i)))   busyD[i] = 1'b0;
    end

    okD  = grantOk || strb.doRel || (strb.doStat && tgtBusy);
    idxD = (strb.reject || (strb.doAcq && !grantOk)) ? FAIL_CODE : tgtIdx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busyQ     <= '0;
      rspValidQ <= '0;
      rspOkQ    <= 1'b0;
      rspIdxQ   <= '0;
    end else begin
      busyQ     <= busyD;
      rspValidQ <= strb.fire ? selPort : '0;
      if (strb.fire) begin
        rspOkQ  <= okD;
        rspIdxQ <= idxD;
      end
    end
  end

  assign busyVec  = busyQ;
  assign rspValid = rspValidQ;
  assign rspOk    = rspOkQ;
  assign rspIdx   = rspIdxQ;

endmodule

// File: rtl/sem_pool.sv
module sem_pool
  import sem_pool_pkg::*;
#(
  parameter int NUM_SEMS = 10,
  parameter int NUM_REQ  = 2,
  parameter int IDX_W    = $clog2(NUM_SEMS + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_REQ-1:0]       reqValid,
  input  logic [2*NUM_REQ-1:0]     reqOp,
  input  logic [IDX_W*NUM_REQ-1:0] reqIdx,
  input  logic [NUM_REQ-1:0]       reqAny,
  output logic [NUM_REQ-1:0]       reqReady,
  output logic [NUM_REQ-1:0]       rspValid,
  output logic                     rspOk,
  output logic [IDX_W-1:0]         rspIdx,
  output logic [NUM_SEMS-1:0]      busyVec
);

  logic [NUM_REQ-1:0] selPort;
  logic               selValid;
  logic [1:0]         selOp;
  logic [IDX_W-1:0]   selIdx;
  logic               selAny;
  semStrb_t           strb;

  sem_pool_arb #(.NUM_REQ(NUM_REQ), .IDX_W(IDX_W)) u_arb (
    .reqValid(reqValid), .reqOp(reqOp), .reqIdx(reqIdx), .reqAny(reqAny),
    .selPort(selPort), .selValid(selValid), .selOp(selOp),
    .selIdx(selIdx), .selAny(selAny)
  );

  sem_pool_ctrl #(.NUM_SEMS(NUM_SEMS), .IDX_W(IDX_W)) u_ctrl (
    .selValid(selValid), .selOp(selOp), .selIdx(selIdx), .selAny(selAny),
    .strb(strb)
  );

  sem_pool_dp #(.NUM_SEMS(NUM_SEMS), .NUM_REQ(NUM_REQ), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .selIdx(selIdx), .selPort(selPort),
    .busyVec(busyVec), .rspValid(rspValid), .rspOk(rspOk), .rspIdx(rspIdx)
  );

  assign reqReady = selPort;

endmodule

// File: rtl/sem_pool_chk.sv
module sem_pool_chk #(
  parameter int NUM_SEMS = 10,
  parameter int NUM_REQ  = 2,
  parameter int IDX_W    = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NUM_REQ-1:0]       reqValid,
  input logic [2*NUM_REQ-1:0]     reqOp,
  input logic [IDX_W*NUM_REQ-1:0] reqIdx,
  input logic [NUM_REQ-1:0]       reqAny,
  input logic [NUM_REQ-1:0]       reqReady,
  input logic [NUM_REQ-1:0]       rspValid,
  input logic                     rspOk,
  input logic [IDX_W-1:0]         rspIdx,
  input logic [NUM_SEMS-1:0]      busyVec
);

  logic                pValQ;
  logic [1:0]          pOpQ;
  logic                pAnyQ;
  logic [IDX_W-1:0]    pIdxQ;
  logic [NUM_SEMS-1:0] prevBusy;
  logic [1:0]          gOp;
  logic                gAny;
  logic [IDX_W-1:0]    gIdx;

  always_comb begin
    gOp = 2'b00; gAny = 1'b0; gIdx = '0;
    for (int p = 0; p < NUM_REQ; p++) begin
      if (reqReady[p]) begin
        gOp  = reqOp[2*p +: 2];
        gAny = reqAny[p];
        gIdx = reqIdx[IDX_W*p +: IDX_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pValQ <= 1'b0; pOpQ <= 2'b00; pAnyQ <= 1'b0; pIdxQ <= '0; prevBusy <= '0;
    end else begin
      pValQ    <= |reqReady;
      pOpQ     <= gOp;
      pAnyQ    <= gAny;
      pIdxQ    <= gIdx;
      prevBusy <= busyVec;
    end
  end

  function automatic logic bitAt(input logic [NUM_SEMS-1:0] v, input logic [IDX_W-1:0] k);
    logic b;
    b = 1'b0;
    for (int i = 0; i < NUM_SEMS; i++) if (k == IDX_W'(i)) b = v[i];
    return b;
  endfunction

  function automatic logic [IDX_W-1:0] lowFree(input logic [NUM_SEMS-1:0] v);
    logic [IDX_W-1:0] r;
    r = '1;
    for (int i = NUM_SEMS - 1; i >= 0; i--) if (!v[i]) r = IDX_W'(i);
    return r;
  endfunction

  logic pAcq, pRel, pStat;
  assign pAcq  = pValQ && (pOpQ == 2'b01);
  assign pRel  = pValQ && (pOpQ == 2'b10);
  assign pStat = pValQ && (pOpQ == 2'b00);

  a_r9_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reqReady));
  a_r9_grant_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (reqReady & ~reqValid) == '0);
  a_r9_one_response: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rspValid));
  a_r2_rsp_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (|rspValid) == pValQ);
  a_r2_grant_marks_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (pAcq && rspOk) |-> bitAt(busyVec, rspIdx));
  a_r10_no_double_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (pAcq && rspOk) |-> !bitAt(prevBusy, rspIdx));
  a_r3_fail_code: assert property (@(posedge clk) disable iff (!rst_n)
    (pAcq && !rspOk) |-> (rspIdx == '1 && busyVec == prevBusy));
  a_r5_full_fails: assert property (@(posedge clk) disable iff (!rst_n)
    (pAcq && pAnyQ) |-> (rspOk == !(&prevBusy)));
  a_r4_lowest_free: assert property (@(posedge clk) disable iff (!rst_n)
    (pAcq && pAnyQ && rspOk) |-> (rspIdx == lowFree(prevBusy)));
  a_r7_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (pRel && rspOk) |-> !bitAt(busyVec, pIdxQ));
  a_r8_status_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    pStat |-> (busyVec == prevBusy));
  a_r11_rsvd_fails: assert property (@(posedge clk) disable iff (!rst_n)
    (pValQ && pOpQ == 2'b11) |-> (!rspOk && rspIdx == '1 && busyVec == prevBusy));

endmodule

bind sem_pool sem_pool_chk #(.NUM_SEMS(NUM_SEMS), .NUM_REQ(NUM_REQ), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqOp(reqOp), .reqIdx(reqIdx),
  .reqAny(reqAny), .reqReady(reqReady), .rspValid(rspValid), .rspOk(rspOk),
  .rspIdx(rspIdx), .busyVec(busyVec)
);

// File: tb/sem_pool_bench.sv
module sem_pool_bench;

  localparam int CLK_PERIOD = 10;
  localparam int N  = 10;
  localparam int NR = 2;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NR-1:0]    reqValid = '0;
  logic [2*NR-1:0]  reqOp = '0;
  logic [IW*NR-1:0] reqIdx = '0;
  logic [NR-1:0]    reqAny = '0;
  logic [NR-1:0]    reqReady;
  logic [NR-1:0]    rspValid;
  logic             rspOk;
  logic [IW-1:0]    rspIdx;
  logic [N-1:0]     busyVec;

  int nTests = 0;
  int nFail  = 0;
  logic [N-1:0] mdl = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sem_pool #(.NUM_SEMS(N), .NUM_REQ(NR)) u_sem_pool (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqOp(reqOp), .reqIdx(reqIdx),
    .reqAny(reqAny), .reqReady(reqReady), .rspValid(rspValid), .rspOk(rspOk),
    .rspIdx(rspIdx), .busyVec(busyVec)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected response from the requirements, updating the model
  task automatic predict(input int op, input int idx, input bit any,
                         output bit eOk, output int eIdx, output string tag);
    eOk = 1'b0; eIdx = 15;
    case (op)
      0: begin tag = (idx < N) ? "R8" : "R6";
         if (idx < N) begin eOk = mdl[idx]; eIdx = idx; end end
      1: if (any) begin
           tag = "R4";
           for (int i = N - 1; i >= 0; i--) if (!mdl[i]) begin eOk = 1'b1; eIdx = i; end
           if (eOk) mdl[eIdx] = 1'b1; else tag = "R5";
         end else if (idx >= N) tag = "R6";
         else if (mdl[idx]) tag = "R3";
         else begin tag = "R2"; eOk = 1'b1; eIdx = idx; mdl[idx] = 1'b1; end
      2: begin tag = (idx < N) ? "R7" : "R6";
         if (idx < N) begin eOk = 1'b1; eIdx = idx; mdl[idx] = 1'b0; end end
      default: tag = "R11";
    endcase
  endtask

  task automatic drive(input int p, input int op, input int idx, input bit any);
    reqValid[p] = 1'b1;
    reqOp[2*p +: 2] = 2'(op);
    reqIdx[IW*p +: IW] = IW'(idx);
    reqAny[p] = any;
  endtask

  task automatic checkRsp(input int p, input bit eOk, input int eIdx, input string tag);
    check(rspValid == NR'(1 << p), {tag, " rspValid"}, int'(rspValid), 1 << p);
    check(rspOk == eOk, {tag, " rspOk"}, int'(rspOk), int'(eOk));
    check(int'(rspIdx) == eIdx, {tag, " rspIdx"}, int'(rspIdx), eIdx);
    check(busyVec == mdl, {tag, " busyVec"}, int'(busyVec), int'(mdl));
  endtask

  task automatic serve(input int p, input int op, input int idx, input bit any);
    bit eOk; int eIdx; string tag;
    @(negedge clk);
    drive(p, op, idx, any);
    #1 check(reqReady == NR'(1 << p), "R9 grant", int'(reqReady), 1 << p);
    @(negedge clk);
    reqValid = '0;
    predict(op, idx, any, eOk, eIdx, tag);
    checkRsp(p, eOk, eIdx, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    bit eOk; int eIdx; string tag;
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busyVec == '0, "R1 busyVec", int'(busyVec), 0);
    check(rspValid == '0, "R1 rspValid", int'(rspValid), 0);
    check(reqReady == '0, "R1 reqReady", int'(reqReady), 0);

    for (int i = 0; i < 16; i++) serve(0, 0, i, 1'b0);          // status on empty pool
    for (int i = 0; i < 16; i += 2) serve(0, 1, i, 1'b0);       // R2 even entries
    for (int i = 0; i < 16; i++) serve(1, 1, i, 1'b0);          // R3 busy, R2 odd, R6
    for (int i = 0; i < 16; i++) serve(1, 0, i, 1'b0);          // R8 full pool
    serve(0, 1, 5, 1'b1);                                       // R5 full
    serve(0, 2, 7, 1'b0); serve(0, 2, 3, 1'b0);
    serve(1, 1, 0, 1'b1); serve(1, 1, 9, 1'b1); serve(0, 1, 2, 1'b1); // R4 picks 3, 7, fail
    for (int i = 0; i < 16; i++) serve(0, 2, i, 1'b0);          // R7 release all
    for (int i = 0; i < 16; i++) serve(1, 2, i, 1'b0);          // R7 release free
    for (int i = 0; i < 16; i++) serve(0, 3, i, i[0]);          // R11 reserved
    serve(0, 1, 4, 1'b0);
    for (int i = 0; i < 16; i++) serve(1, 3, i, 1'b0);          // R11 with a busy entry

    // R10 / R9: both ports acquire entry 6 in the same cycle
    @(negedge clk);
    drive(0, 1, 6, 1'b0); drive(1, 1, 6, 1'b0);
    #1 check(reqReady == 2'b01, "R9 priority", int'(reqReady), 1);
    @(negedge clk);
    reqValid[0] = 1'b0;
    predict(1, 6, 1'b0, eOk, eIdx, tag);
    checkRsp(0, eOk, eIdx, "R10 first");
    #1 check(reqReady == 2'b10, "R9 second", int'(reqReady), 2);
    @(negedge clk);
    reqValid = '0;
    predict(1, 6, 1'b0, eOk, eIdx, tag);
    checkRsp(1, eOk, eIdx, "R10 second");
    check(eOk == 1'b0, "R10 model", int'(eOk), 0);

    // R9: two "any" acquires in one cycle get distinct entries
    @(negedge clk);
    drive(0, 1, 0, 1'b1); drive(1, 1, 0, 1'b1);
    @(negedge clk);
    reqValid[0] = 1'b0;
    predict(1, 0, 1'b1, eOk, eIdx, tag);
    checkRsp(0, eOk, eIdx, "R9 any first");
    @(negedge clk);
    reqValid = '0;
    predict(1, 0, 1'b1, eOk, eIdx, tag);
    checkRsp(1, eOk, eIdx, "R9 any second");

    // mixed pseudo-random stream
    lfsr = 16'hACE1;
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      serve(int'(lfsr[0]), (lfsr[3:2] == 2'b11) ? 1 : int'(lfsr[3:2]),
            int'(lfsr[7:4]) % 12, lfsr[8]);
    end

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule